// File: doc/BRIEF.md
# Per-Line Video Memory Slot Sequencer

This block paces the video memory of a tile-based display controller. Every scan line is cut into 172 access windows, and each window carries exactly one kind of memory cycle. The block keeps a window counter and a line counter. For each window it names the cycle type: a tile name fetch, a tile pattern fetch, a DRAM refresh, or a slot handed to the host processor. For the two fetch types it also forms the 14-bit memory address and the line-buffer column that the fetched byte belongs in.

Two line schedules are built in. Active lines in 40-column text mode use the text schedule: a long run of host slots, then 40 column groups, then a short run of host slots. Every other line uses the refresh schedule. That covers the border and blanking lines, and active lines whenever text mode is off. A window advances on each cycle where `step` is high. The pixel clock runs at twice the window rate, so a surrounding design asserts `step` on every second pixel clock. The fetched name byte comes back on `name_data` during the name window. The block holds it so that it can form the pattern address two windows later.

Top module: `vram_slot_sequencer`

## Requirements
- R1: After reset the window index and the line index are both 0.
- R2: The window index goes up by one on each clock with `step` high and holds when `step` is low. From 171 it goes back to 0, and the line index then moves to the next line.
- R3: The line index goes back to 0 after line 261 when `pal_mode` is 0, and after line 312 when `pal_mode` is 1.
- R4: In every window exactly one of `name_fetch`, `pattern_fetch`, `refresh` and `ext_grant` is high.
- R5: On a text line (`text_mode` high and line index below 192), windows 0 to 46 and windows 167 to 171 are host slots.
- R6: On a text line, windows 47 to 166 form 40 groups of three windows: name fetch, host slot, pattern fetch. Group g (g = (window-47)/3) drives `lb_col` = g in its name window and in its pattern window.
- R7: On any line that is not a text line, windows 0 to 43 are host slots. From window 44 on, even windows are refresh and odd windows are host slots.
- R8: In a name window, `vram_addr` = (`name_base` AND (0x3C00 OR (line>>3)*40)) + column, cut to 14 bits.
- R9: In a pattern window, `vram_addr` = (`pattern_base` AND (0x3800 OR (line AND 7))) + 8 * N, cut to 14 bits. N is the `name_data` byte sampled at the end of the same group's name window.
- R10: During a host slot `ext_column` is twice the window index. In all other windows it is 0. `vram_addr` and `lb_col` are 0 in every window that is neither a name fetch nor a pattern fetch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| step | input | 1 | Advance to the next access window |
| pal_mode | input | 1 | 0: 262-line frame, 1: 313-line frame |
| text_mode | input | 1 | Use the 40-column text schedule on active lines |
| name_base | input | 14 | Name table base mask |
| pattern_base | input | 14 | Pattern table base mask |
| name_data | input | 8 | Name byte returned during a name fetch window |
| window | output | 8 | Current access window, 0 to 171 |
| row | output | 9 | Current line index |
| name_fetch | output | 1 | Window is a tile name fetch |
| pattern_fetch | output | 1 | Window is a tile pattern fetch |
| refresh | output | 1 | Window is a DRAM refresh |
| ext_grant | output | 1 | Window is a host access slot |
| ext_column | output | 9 | Access column of the host slot (twice the window) |
| vram_addr | output | 14 | Memory address for name or pattern fetches |
| lb_col | output | 6 | Line-buffer column for the fetched byte |

## Verification
Some properties are checked by assertions on every cycle. These are: one strobe per window; the window index staying in range and holding while `step` is low; the wrap to window 0; a host slot always following a name fetch; text column indices stay below 40; refresh occurs only in even windows. The bench has to show what no single-cycle property can. It scans whole lines and compares the exact window map for both schedules. It checks the address arithmetic for different bases and lines. It checks that the pattern address uses the name byte captured two windows earlier, and that both frame lengths wrap at the right line.

// File: rtl/vslot_pkg.sv
package vslot_pkg;
    localparam int WINDOWS       = 172;
    localparam int TEXT_LEAD     = 47;
    localparam int TEXT_COLS     = 40;
    localparam int REFRESH_LEAD  = 44;
    localparam int WIN_W         = 8;
    localparam int COL_W         = 6;
    localparam int VRAM_AW       = 14;
    localparam int TEXT_END      = TEXT_LEAD + 3 * TEXT_COLS;

    typedef enum logic [1:0] {
        SLOT_EXT  = 2'd0,
        SLOT_NAME = 2'd1,
        SLOT_PAT  = 2'd2,
        SLOT_RFSH = 2'd3
    } slot_kind_e;

    typedef struct packed {
        slot_kind_e         kind;
        logic [COL_W-1:0]   col;
    } slot_t;

    function automatic slot_t decode_slot(input logic [WIN_W-1:0] win, input logic text_line);
        slot_t            s;
        logic [WIN_W-1:0] k;
        s.kind = SLOT_EXT;
        s.col  = '0;
        k      = '0;
        if (text_line) begin
            if (win >= WIN_W'(TEXT_LEAD) && win < WIN_W'(TEXT_END)) begin
                k     = win - WIN_W'(TEXT_LEAD);
                s.col = COL_W'(k / WIN_W'(3));
                case (k % WIN_W'(3))
                    WIN_W'(0): s.kind = SLOT_NAME;
                    WIN_W'(2): s.kind = SLOT_PAT;
                    default:   s.kind = SLOT_EXT;
                endcase
            end
        end else if (win >= WIN_W'(REFRESH_LEAD) && !win[0]) begin
            s.kind = SLOT_RFSH;
        end
        return s;
    endfunction
endpackage

// File: rtl/vslot_window_ctr.sv
module vslot_window_ctr
    import vslot_pkg::*;
#(
    parameter int NTSC_LINES = 262,
    parameter int PAL_LINES  = 313,
    parameter int ROW_W      = $clog2(PAL_LINES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              step,
    input  logic              pal_mode,
    output logic [WIN_W-1:0]  win,
    output logic [ROW_W-1:0]  row
);
    localparam logic [WIN_W-1:0] LAST_WIN = WIN_W'(WINDOWS - 1);
    localparam logic [ROW_W-1:0] NTSC_LAST = ROW_W'(NTSC_LINES - 1);
    localparam logic [ROW_W-1:0] PAL_LAST  = ROW_W'(PAL_LINES - 1);

    logic [ROW_W-1:0] last_row;
    assign last_row = pal_mode ? PAL_LAST : NTSC_LAST;

    always_ff @(posedge clk) begin
        if (rst) begin
            win <= '0;
            row <= '0;
        end else if (step) begin
            if (win == LAST_WIN) begin
                win <= '0;
                row <= (row >= last_row) ? '0 : row + 1'b1;
            end else begin
                win <= win + 1'b1;
            end
        end
    end

    AST_WIN_RANGE: assert property (@(posedge clk) disable iff (rst) win <= LAST_WIN); // R2
    AST_WIN_HOLD:  assert property (@(posedge clk) disable iff (rst) !step |=> $stable(win)); // R2
    AST_WIN_WRAP:  assert property (@(posedge clk) disable iff (rst) (step && win == LAST_WIN) |=> (win == '0)); // R2
    AST_ROW_RANGE: assert property (@(posedge clk) disable iff (rst) row <= PAL_LAST); // R3
endmodule

// File: rtl/vslot_decode.sv
module vslot_decode
    import vslot_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              step,
    input  logic [WIN_W-1:0]  win,
    input  logic              text_line,
    output logic              name_fetch,
    output logic              pattern_fetch,
    output logic              refresh,
    output logic              ext_grant,
    output logic [COL_W-1:0]  col
);
    slot_t slot;

    always_comb begin
        slot          = decode_slot(win, text_line);
        name_fetch    = (slot.kind == SLOT_NAME);
        pattern_fetch = (slot.kind == SLOT_PAT);
        refresh       = (slot.kind == SLOT_RFSH);
        ext_grant     = (slot.kind == SLOT_EXT);
        col           = (name_fetch || pattern_fetch) ? slot.col : '0;
    end

    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (rst)
        $countones({name_fetch, pattern_fetch, refresh, ext_grant}) == 1); // R4
    AST_NAME_THEN_HOST: assert property (@(posedge clk) disable iff (rst)
        (name_fetch && step) |=> ext_grant); // R6
    AST_COL_LIMIT: assert property (@(posedge clk) disable iff (rst)
        (name_fetch || pattern_fetch) |-> (col < COL_W'(TEXT_COLS))); // R6
    AST_RFSH_EVEN: assert property (@(posedge clk) disable iff (rst)
        refresh |-> !win[0]); // R7
endmodule

// File: rtl/vslot_addr_gen.sv
module vslot_addr_gen
    import vslot_pkg::*;
#(
    parameter int ROW_W = 9
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                step,
    input  logic [ROW_W-1:0]    row,
    input  logic [COL_W-1:0]    col,
    input  logic                name_fetch,
    input  logic                pattern_fetch,
    input  logic [VRAM_AW-1:0]  name_base,
    input  logic [VRAM_AW-1:0]  pattern_base,
    input  logic [7:0]          name_data,
    output logic [VRAM_AW-1:0]  vram_addr
);
    localparam logic [VRAM_AW-1:0] NAME_KEEP = VRAM_AW'(14'h3C00);
    localparam logic [VRAM_AW-1:0] PAT_KEEP  = VRAM_AW'(14'h3800);

    logic [7:0]         name_q;
    logic [VRAM_AW-1:0] row_span;
    logic [VRAM_AW-1:0] name_addr;
    logic [VRAM_AW-1:0] pat_addr;

    always_ff @(posedge clk) begin
        if (rst)                     name_q <= '0;
        else if (step && name_fetch) name_q <= name_data;
    end

    always_comb begin
        row_span  = VRAM_AW'(row >> 3) * VRAM_AW'(TEXT_COLS);
        name_addr = (name_base & (NAME_KEEP | row_span)) + VRAM_AW'(col);
        pat_addr  = (pattern_base & (PAT_KEEP | VRAM_AW'(row[2:0])))
                    + (VRAM_AW'(name_q) << 3);
        if (name_fetch)         vram_addr = name_addr;
        else if (pattern_fetch) vram_addr = pat_addr;
        else                    vram_addr = '0;
    end

    AST_IDLE_ADDR: assert property (@(posedge clk) disable iff (rst)
        !(name_fetch || pattern_fetch) |-> (vram_addr == '0)); // R10
endmodule

// File: rtl/vram_slot_sequencer.sv
module vram_slot_sequencer
    import vslot_pkg::*;
#(
    parameter int NTSC_LINES   = 262,
    parameter int PAL_LINES    = 313,
    parameter int ACTIVE_LINES = 192
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        step,
    input  logic        pal_mode,
    input  logic        text_mode,
    input  logic [13:0] name_base,
    input  logic [13:0] pattern_base,
    input  logic [7:0]  name_data,
    output logic [7:0]  window,
    output logic [8:0]  row,
    output logic        name_fetch,
    output logic        pattern_fetch,
    output logic        refresh,
    output logic        ext_grant,
    output logic [8:0]  ext_column,
    output logic [13:0] vram_addr,
    output logic [5:0]  lb_col
);
    localparam int ROW_W = 9;

    logic text_line;

    vslot_window_ctr #(
        .NTSC_LINES (NTSC_LINES),
        .PAL_LINES  (PAL_LINES),
        .ROW_W      (ROW_W)
    ) u_ctr (
        .clk      (clk),
        .rst      (rst),
        .step     (step),
        .pal_mode (pal_mode),
        .win      (window),
        .row      (row)
    );

    assign text_line = text_mode && (row < ROW_W'(ACTIVE_LINES));

    vslot_decode u_dec (
        .clk           (clk),
        .rst           (rst),
        .step          (step),
        .win           (window),
        .text_line     (text_line),
        .name_fetch    (name_fetch),
        .pattern_fetch (pattern_fetch),
        .refresh       (refresh),
        .ext_grant     (ext_grant),
        .col           (lb_col)
    );

    vslot_addr_gen #(
        .ROW_W (ROW_W)
    ) u_addr (
        .clk           (clk),
        .rst           (rst),
        .step          (step),
        .row           (row),
        .col           (lb_col),
        .name_fetch    (name_fetch),
        .pattern_fetch (pattern_fetch),
        .name_base     (name_base),
        .pattern_base  (pattern_base),
        .name_data     (name_data),
        .vram_addr     (vram_addr)
    );

    assign ext_column = ext_grant ? {window, 1'b0} : 9'd0;

    AST_HOST_ONLY_TEXT_EDGE: assert property (@(posedge clk) disable iff (rst)
        (text_line && (window < 8'd47 || window > 8'd166)) |-> ext_grant); // R5
endmodule

// File: tb/vram_slot_sequencer_tb.sv
module vram_slot_sequencer_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        step = 1'b0;
    logic        pal_mode = 1'b0;
    logic        text_mode = 1'b1;
    logic [13:0] name_base = 14'h3FFF;
    logic [13:0] pattern_base = 14'h3FFF;
    logic [7:0]  name_data;
    logic [7:0]  window;
    logic [8:0]  row;
    logic        name_fetch, pattern_fetch, refresh, ext_grant;
    logic [8:0]  ext_column;
    logic [13:0] vram_addr;
    logic [5:0]  lb_col;

    int vectors = 0;
    int errors  = 0;
    int exp_w   = 0;
    int exp_row = 0;

    always #10 clk = ~clk;

    // memory model: name byte depends on column and line
    assign name_data = 8'(int'(lb_col) * 7 + int'(row[2:0]) * 3 + 1);

    vram_slot_sequencer u_dut (
        .clk(clk), .rst(rst), .step(step), .pal_mode(pal_mode), .text_mode(text_mode),
        .name_base(name_base), .pattern_base(pattern_base), .name_data(name_data),
        .window(window), .row(row), .name_fetch(name_fetch), .pattern_fetch(pattern_fetch),
        .refresh(refresh), .ext_grant(ext_grant), .ext_column(ext_column),
        .vram_addr(vram_addr), .lb_col(lb_col)
    );

    function automatic int nd(input int c, input int r);
        return (c * 7 + (r % 8) * 3 + 1) % 256;
    endfunction

    // 0 host, 1 name, 2 pattern, 3 refresh
    function automatic int exp_kind(input int w, input int r);
        if (text_mode && r < 192) begin
            if (w < 47 || w > 166) return 0;
            case ((w - 47) % 3)
                0: return 1;
                2: return 2;
                default: return 0;
            endcase
        end
        if (w >= 44 && (w % 2) == 0) return 3;
        return 0;
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d (line %0d window %0d)", tag, act, exp, exp_row, exp_w);
        end
    endtask

    task automatic adv();
        int last;
        last = pal_mode ? 312 : 261;
        if (exp_w == 171) begin
            exp_w = 0;
            exp_row = (exp_row >= last) ? 0 : exp_row + 1;
        end else exp_w++;
    endtask

    task automatic check_window(input string tag);
        int k, c, ea;
        k  = exp_kind(exp_w, exp_row);
        c  = (k == 1 || k == 2) ? (exp_w - 47) / 3 : 0;
        ea = 0;
        if (k == 1) ea = ((int'(name_base) & (16'h3C00 | (exp_row / 8) * 40)) + c) % 16384;
        if (k == 2) ea = ((int'(pattern_base) & (16'h3800 | (exp_row % 8))) + nd(c, exp_row) * 8) % 16384;
        chk({tag, " R2 window"}, int'(window), exp_w);
        chk({tag, " R4 name"}, int'(name_fetch), int'(k == 1));
        chk({tag, " R4 pattern"}, int'(pattern_fetch), int'(k == 2));
        chk({tag, " R4 refresh"}, int'(refresh), int'(k == 3));
        chk({tag, " R4 grant"}, int'(ext_grant), int'(k == 0));
        chk({tag, " R10 column"}, int'(ext_column), (k == 0) ? 2 * exp_w : 0);
        chk({tag, " R8/R9 addr"}, int'(vram_addr), ea);
        chk({tag, " R6 lb_col"}, int'(lb_col), c);
    endtask

    task automatic scan_line(input string tag);
        for (int i = 0; i < 172; i++) begin
            check_window(tag);
            @(negedge clk); adv();
        end
    endtask

    task automatic run_to(input int r, input int w);
        while (!(exp_row == r && exp_w == w)) begin
            @(negedge clk); adv();
        end
    endtask

    task automatic t_reset();
        chk("R1 window", int'(window), 0);
        chk("R1 row", int'(row), 0);
        chk("R1 grant column", int'(ext_column), 0);
    endtask

    task automatic t_text_line0();
        text_mode = 1'b1; name_base = 14'h3FFF; pattern_base = 14'h3FFF;
        scan_line("R5 R6 text line 0");
    endtask

    task automatic t_hold();
        int w0;
        step = 1'b0;
        w0 = exp_w;
        repeat (4) begin
            @(negedge clk);
            chk("R2 hold window", int'(window), w0);
            chk("R2 hold row", int'(row), exp_row);
        end
        step = 1'b1;
    endtask

    task automatic t_refresh_textoff();
        text_mode = 1'b0;
        scan_line("R7 text off");
        text_mode = 1'b1;
    endtask

    task automatic t_text_line9();
        run_to(9, 0);
        name_base = 14'h2FFF; pattern_base = 14'h2805;
        scan_line("R8 R9 text line 9");
    endtask

    task automatic t_border();
        run_to(200, 0);
        scan_line("R7 border line");
    endtask

    task automatic t_wrap_ntsc();
        run_to(261, 171);
        chk("R3 last ntsc row", int'(row), 261);
        @(negedge clk); adv();
        chk("R3 ntsc wrap row", int'(row), 0);
        chk("R2 wrap window", int'(window), 0);
    endtask

    task automatic t_wrap_pal();
        pal_mode = 1'b1;
        run_to(262, 0);
        chk("R3 pal passes 262", int'(row), 262);
        run_to(312, 171);
        chk("R3 last pal row", int'(row), 312);
        @(negedge clk); adv();
        chk("R3 pal wrap row", int'(row), 0);
        chk("R3 pal wrap window", int'(window), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        step = 1'b1;
        t_text_line0();
        t_hold();
        t_refresh_textoff();
        t_text_line9();
        t_border();
        t_wrap_ntsc();
        t_wrap_pal();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule